// File: doc/BRIEF.md
# Two-Way Vector Interleave Unit

This block merges two source vectors, each `VL` bits long, into a pair of destination vectors. Elements are taken alternately from the first and the second source. The first destination receives the interleave of the lower halves of both sources. The second destination receives the interleave of the upper halves. Elements may be 8, 16, 32, 64 or 128 bits wide. The 128-bit width is only legal on a vector of at least 256 bits. No element is masked: every element of both results is written.

A small front end decodes a 32-bit instruction word. It recognises two fixed bit patterns: one carries a 2-bit size field, and the other fixes the element at 128 bits. From the word it extracts the source and destination register numbers and flags words it cannot accept. A result is captured in one register stage when `in_valid` is high. The results stay unchanged until the next accepted word.

Top module: `zipx_unit`

## Requirements
- R1: In the sized pattern (bits 31..24 = 8'hC1, bit 21 = 1, bits 15..10 = 6'b110100, bit 0 = 0), bits 23..22 give `elem_code` 0..3, meaning elements of 8 << size bits.
- R2: The wide pattern (bits 31..24 = 8'hC1, bits 23..21 = 3'b001, bits 15..10 = 6'b110101, bit 0 = 0) gives `elem_code` 4 (128-bit elements). It is undefined when `VL` < 256.
- R3: A word matching neither pattern sets `no_match` and `undef`, and reports `elem_code` 0.
- R4: `rd_lo` = {bits 4..1, 1'b0}, `rd_hi` = {bits 4..1, 1'b1}, `rn` = bits 9..5, `rm` = bits 20..16.
- R5: With E the element width and P = VL/(2E), element 2p of `dst_lo` is element p of `src_a`, and element 2p+1 is element p of `src_b`. Element i occupies bits [i*E +: E].
- R6: Element 2p of `dst_hi` is element P+p of `src_a`, and element 2p+1 is element P+p of `src_b`.
- R7: An undefined word sets `undef` and drives both result vectors to zero. A word is undefined when R3 applies, when R2 applies, or when VL < 2E.
- R8: Every output is registered. It reflects the word presented one cycle earlier with `in_valid` high, and `out_valid` follows `in_valid` by one cycle. After reset every output is zero.
- R9: While `in_valid` is low, all result outputs hold their last values whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Accept the word and sources this cycle |
| instr | input | 32 | Instruction word |
| src_a | input | VL | First source vector |
| src_b | input | VL | Second source vector |
| out_valid | output | 1 | Result registered from an accepted word |
| undef | output | 1 | Word cannot be executed |
| no_match | output | 1 | Word matches neither pattern |
| elem_code | output | 3 | Element width code, 8 << code bits |
| rd_lo | output | 5 | First destination register number |
| rd_hi | output | 5 | Second destination register number |
| rn | output | 5 | First source register number |
| rm | output | 5 | Second source register number |
| dst_lo | output | VL | Interleave of the lower halves |
| dst_hi | output | VL | Interleave of the upper halves |

## Verification
The hardest case to reach from the ports is the 128-bit form on a short vector. The same word is legal on a wide unit and must be rejected on a narrow one. The bench drives one word into three copies of the unit, built at 512, 256 and 128 bits. It then checks that only the 128-bit copy zeroes its results and raises `undef`. Near-miss words, each differing from a pattern in one fixed bit, are used to reach `no_match`.

// File: rtl/zipx_pkg.sv
package zipx_pkg;
  typedef enum logic [2:0] {
    EW8   = 3'd0,
    EW16  = 3'd1,
    EW32  = 3'd2,
    EW64  = 3'd3,
    EW128 = 3'd4
  } ew_code_e;

  localparam int NUM_EW = 5;

  typedef struct packed {
    logic     sized_hit;
    logic     wide_hit;
    ew_code_e code;
    logic [4:0] rd_lo;
    logic [4:0] rd_hi;
    logic [4:0] rn;
    logic [4:0] rm;
  } dec_t;

  function automatic int ew_bits(input logic [2:0] code);
    return 8 << code;
  endfunction

  function automatic logic ew_fits(input logic [2:0] code, input int vl);
    return vl >= 2 * ew_bits(code);
  endfunction
endpackage

// File: rtl/zipx_decode.sv
module zipx_decode
  import zipx_pkg::*;
(
  input  logic [31:0] instr,
  output dec_t        dec
);
  logic top_ok;
  logic sized_hit;
  logic wide_hit;

  assign top_ok    = (instr[31:24] == 8'hC1) && (instr[0] == 1'b0);
  assign sized_hit = top_ok && instr[21] && (instr[15:10] == 6'b110100);
  assign wide_hit  = top_ok && (instr[23:21] == 3'b001) && (instr[15:10] == 6'b110101);

  always_comb begin
    dec.sized_hit = sized_hit;
    dec.wide_hit  = wide_hit;
    if (wide_hit)       dec.code = EW128;
    else if (sized_hit) dec.code = ew_code_e'({1'b0, instr[23:22]});
    else                dec.code = EW8;
    dec.rd_lo = {instr[4:1], 1'b0};
    dec.rd_hi = {instr[4:1], 1'b1};
    dec.rn    = instr[9:5];
    dec.rm    = instr[20:16];
  end
endmodule

// File: rtl/zipx_network.sv
module zipx_network
  import zipx_pkg::*;
#(
  parameter int VL = 512
) (
  input  logic [VL-1:0] a,
  input  logic [VL-1:0] b,
  input  logic [2:0]    code,
  output logic [VL-1:0] lo,
  output logic [VL-1:0] hi
);
  logic [VL-1:0] lo_k [NUM_EW];
  logic [VL-1:0] hi_k [NUM_EW];

  for (genvar k = 0; k < NUM_EW; k++) begin : g_ew
    localparam int ES = 8 << k;
    if (VL >= 2 * ES) begin : g_fit
      localparam int PAIRS = VL / (2 * ES);
      for (genvar p = 0; p < PAIRS; p++) begin : g_pair
        assign lo_k[k][(2*p)*ES   +: ES] = a[p*ES +: ES];
        assign lo_k[k][(2*p+1)*ES +: ES] = b[p*ES +: ES];
        assign hi_k[k][(2*p)*ES   +: ES] = a[(PAIRS+p)*ES +: ES];
        assign hi_k[k][(2*p+1)*ES +: ES] = b[(PAIRS+p)*ES +: ES];
      end
    end else begin : g_nofit
      assign lo_k[k] = '0;
      assign hi_k[k] = '0;
    end
  end

  always_comb begin
    lo = '0;
    hi = '0;
    for (int k = 0; k < NUM_EW; k++) begin
      if (code == 3'(k)) begin
        lo = lo_k[k];
        hi = hi_k[k];
      end
    end
  end
endmodule

// File: rtl/zipx_unit.sv
module zipx_unit
  import zipx_pkg::*;
#(
  parameter int VL = 512
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [31:0]   instr,
  input  logic [VL-1:0] src_a,
  input  logic [VL-1:0] src_b,
  output logic          out_valid,
  output logic          undef,
  output logic          no_match,
  output logic [2:0]    elem_code,
  output logic [4:0]    rd_lo,
  output logic [4:0]    rd_hi,
  output logic [4:0]    rn,
  output logic [4:0]    rm,
  output logic [VL-1:0] dst_lo,
  output logic [VL-1:0] dst_hi
);
  localparam int WIDE_MIN_VL = 256;
  localparam logic WIDE_OK = (VL >= WIDE_MIN_VL);

  dec_t          dec;
  logic          ev_nomatch;
  logic          ev_wide_blocked;
  logic          ev_too_short;
  logic          ev_undef;
  logic [VL-1:0] net_lo;
  logic [VL-1:0] net_hi;

  zipx_decode u_dec (
    .instr (instr),
    .dec   (dec)
  );

  zipx_network #(.VL(VL)) u_net (
    .a    (src_a),
    .b    (src_b),
    .code (dec.code),
    .lo   (net_lo),
    .hi   (net_hi)
  );

  assign ev_nomatch      = !(dec.sized_hit || dec.wide_hit);
  assign ev_wide_blocked = dec.wide_hit && !WIDE_OK;
  assign ev_too_short    = !ew_fits(dec.code, VL);
  assign ev_undef        = ev_nomatch || ev_wide_blocked || ev_too_short;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      undef     <= 1'b0;
      no_match  <= 1'b0;
      elem_code <= '0;
      rd_lo     <= '0;
      rd_hi     <= '0;
      rn        <= '0;
      rm        <= '0;
      dst_lo    <= '0;
      dst_hi    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        undef     <= ev_undef;
        no_match  <= ev_nomatch;
        elem_code <= dec.code;
        rd_lo     <= dec.rd_lo;
        rd_hi     <= dec.rd_hi;
        rn        <= dec.rn;
        rm        <= dec.rm;
        dst_lo    <= ev_undef ? '0 : net_lo;
        dst_hi    <= ev_undef ? '0 : net_hi;
      end
    end
  end

  a_r3_nomatch_is_undef: assert property (@(posedge clk) disable iff (!rst_n)
    no_match |-> undef);

  a_r3_patterns_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dec.sized_hit, dec.wide_hit}));

  a_r7_undef_zero: assert property (@(posedge clk) disable iff (!rst_n)
    undef |-> (dst_lo == '0 && dst_hi == '0));

  a_r8_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r4_pair_numbers: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (rd_hi == rd_lo + 5'd1));

  a_r5_first_byte_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !ev_undef && dec.code == EW8) |=>
      (dst_lo[7:0] == $past(src_a[7:0]) && dst_lo[15:8] == $past(src_b[7:0])));

  a_r6_upper_half_start: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !ev_undef && dec.code == EW8) |=>
      (dst_hi[7:0] == $past(src_a[VL/2 +: 8])));

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(dst_lo) && $stable(dst_hi) && $stable(undef)));

  a_r2_wide_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && dec.wide_hit) |=> (undef == !WIDE_OK));
endmodule

// File: tb/sim_zipx_unit.sv
module sim_zipx_unit;
  localparam int CLK_PERIOD = 10;
  localparam int MAXV = 512;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [31:0] instr = '0;
  logic [MAXV-1:0] a = '0;
  logic [MAXV-1:0] b = '0;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  logic ov0, u0_ud, nm0; logic [2:0] c0; logic [4:0] rl0, rh0, n0, m0;
  logic [511:0] dl0, dh0;
  logic ov1, u1_ud, nm1; logic [2:0] c1; logic [4:0] rl1, rh1, n1, m1;
  logic [255:0] dl1, dh1;
  logic ov2, u2_ud, nm2; logic [2:0] c2; logic [4:0] rl2, rh2, n2, m2;
  logic [127:0] dl2, dh2;

  zipx_unit #(.VL(512)) u0 (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
    .src_a(a), .src_b(b), .out_valid(ov0), .undef(u0_ud), .no_match(nm0), .elem_code(c0),
    .rd_lo(rl0), .rd_hi(rh0), .rn(n0), .rm(m0), .dst_lo(dl0), .dst_hi(dh0));
  zipx_unit #(.VL(256)) u1 (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
    .src_a(a[255:0]), .src_b(b[255:0]), .out_valid(ov1), .undef(u1_ud), .no_match(nm1),
    .elem_code(c1), .rd_lo(rl1), .rd_hi(rh1), .rn(n1), .rm(m1), .dst_lo(dl1), .dst_hi(dh1));
  zipx_unit #(.VL(128)) u2 (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
    .src_a(a[127:0]), .src_b(b[127:0]), .out_valid(ov2), .undef(u2_ud), .no_match(nm2),
    .elem_code(c2), .rd_lo(rl2), .rd_hi(rh2), .rn(n2), .rm(m2), .dst_lo(dl2), .dst_hi(dh2));

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [511:0] rnd512();
    logic [511:0] r;
    for (int i = 0; i < 16; i++) r[i*32 +: 32] = $urandom;
    return r;
  endfunction

  function automatic logic [31:0] mk_sized(input logic [1:0] sz, input logic [4:0] zm,
                                           input logic [4:0] zn, input logic [3:0] zd);
    return {8'hC1, sz, 1'b1, zm, 6'b110100, zn, zd, 1'b0};
  endfunction

  function automatic logic [31:0] mk_wide(input logic [4:0] zm, input logic [4:0] zn,
                                          input logic [3:0] zd);
    return {8'hC1, 3'b001, zm, 6'b110101, zn, zd, 1'b0};
  endfunction

  // Reference model: loops over pairs and bits, written from R5/R6
  function automatic logic [511:0] ref_zip(input logic [511:0] sa, input logic [511:0] sb,
                                           input int vl, input int es, input int half);
    logic [511:0] res = '0;
    int pairs = vl / (2 * es);
    for (int p = 0; p < pairs; p++)
      for (int j = 0; j < es; j++) begin
        res[(2*p)*es + j]   = sa[(half*pairs + p)*es + j];
        res[(2*p+1)*es + j] = sb[(half*pairs + p)*es + j];
      end
    return res;
  endfunction

  task automatic apply(input logic [31:0] w, input logic [511:0] sa, input logic [511:0] sb);
    @(negedge clk);
    instr = w; a = sa; b = sb; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic check_one(input int vl, input logic [31:0] w, input string tag,
      input logic ov, input logic ud, input logic nm, input logic [2:0] code,
      input logic [4:0] rl, input logic [4:0] rh, input logic [4:0] n, input logic [4:0] m,
      input logic [511:0] dl, input logic [511:0] dh);
    bit s_hit = (w[31:24] == 8'hC1) && w[21] && (w[15:10] == 6'b110100) && !w[0];
    bit w_hit = (w[31:24] == 8'hC1) && (w[23:21] == 3'b001) && (w[15:10] == 6'b110101) && !w[0];
    bit e_nm = !(s_hit || w_hit);
    int e_code = w_hit ? 4 : (s_hit ? int'(w[23:22]) : 0);
    int es = 8 << e_code;
    bit e_ud = e_nm || (w_hit && vl < 256) || (vl < 2 * es);
    logic [511:0] mask = (vl == 512) ? '1 : ((512'd1 << vl) - 512'd1);
    logic [511:0] e_lo = e_ud ? '0 : (ref_zip(a, b, vl, es, 0) & mask);
    logic [511:0] e_hi = e_ud ? '0 : (ref_zip(a, b, vl, es, 1) & mask);
    chk(ov == 1'b1, "R8", {tag, " out_valid"}, 512'(ov), 512'd1);
    chk(nm == e_nm, "R3", {tag, " no_match"}, 512'(nm), 512'(e_nm));
    chk(ud == e_ud, w_hit ? "R2" : "R7", {tag, " undef"}, 512'(ud), 512'(e_ud));
    chk(int'(code) == e_code, s_hit ? "R1" : "R2", {tag, " elem_code"}, 512'(code), 512'(e_code));
    chk(rl == {w[4:1], 1'b0} && rh == {w[4:1], 1'b1} && n == w[9:5] && m == w[20:16],
        "R4", {tag, " register numbers"}, {rl, rh, n, m}, {w[4:1], 1'b0, w[4:1], 1'b1, w[9:5], w[20:16]});
    chk(dl == e_lo, e_ud ? "R7" : "R5", {tag, " dst_lo"}, dl, e_lo);
    chk(dh == e_hi, e_ud ? "R7" : "R6", {tag, " dst_hi"}, dh, e_hi);
  endtask

  task automatic check_all(input logic [31:0] w, input string tag);
    check_one(512, w, {tag, " vl512"}, ov0, u0_ud, nm0, c0, rl0, rh0, n0, m0, dl0, dh0);
    check_one(256, w, {tag, " vl256"}, ov1, u1_ud, nm1, c1, rl1, rh1, n1, m1, 512'(dl1), 512'(dh1));
    check_one(128, w, {tag, " vl128"}, ov2, u2_ud, nm2, c2, rl2, rh2, n2, m2, 512'(dl2), 512'(dh2));
  endtask

  task automatic t_reset();
    chk(!ov0 && !u0_ud && !nm0 && c0 == 0 && dl0 == '0 && dh0 == '0 && rl0 == 0 && rh0 == 0,
        "R8", "reset state vl512", {ov0, u0_ud, nm0, c0, dl0[7:0]}, '0);
    chk(!ov2 && !u2_ud && dl2 == '0 && dh2 == '0, "R8", "reset state vl128",
        512'(dl2), '0);
  endtask

  task automatic t_sizes();
    for (int sz = 0; sz < 4; sz++)
      for (int rep = 0; rep < 3; rep++) begin
        logic [31:0] w = mk_sized(2'(sz), 5'($urandom), 5'($urandom), 4'($urandom));
        apply(w, rnd512(), rnd512());
        check_all(w, $sformatf("R1 R5 R6 size%0d", sz));
      end
  endtask

  task automatic t_patterns();
    logic [31:0] w = mk_sized(2'd2, 5'd0, 5'd0, 4'd0);
    logic [511:0] ia = '0, ib = '1;
    for (int i = 0; i < 64; i++) ia[i*8 +: 8] = 8'(i);
    apply(w, ia, ib);
    check_all(w, "R5 R6 ramp vs ones");
    w = mk_sized(2'd0, 5'd31, 5'd31, 4'd15);
    apply(w, ia, ~ia);
    check_all(w, "R4 max register fields");
  endtask

  task automatic t_wide();
    for (int rep = 0; rep < 2; rep++) begin
      logic [31:0] w = mk_wide(5'($urandom), 5'($urandom), 4'($urandom));
      apply(w, rnd512(), rnd512());
      check_all(w, "R2 wide form");
    end
  endtask

  task automatic t_nomatch();
    logic [31:0] base = mk_sized(2'd1, 5'd3, 5'd4, 4'd5);
    logic [31:0] wb = mk_wide(5'd3, 5'd4, 4'd5);
    apply(base | 32'h1, rnd512(), rnd512());
    check_all(base | 32'h1, "R3 bit0 set");
    apply(base ^ 32'h0100_0000, rnd512(), rnd512());
    check_all(base ^ 32'h0100_0000, "R3 top byte");
    apply(base ^ 32'h0000_0400, rnd512(), rnd512());
    check_all(base ^ 32'h0000_0400, "R3 opcode bits");
    apply(wb ^ 32'h0040_0000, rnd512(), rnd512());
    check_all(wb ^ 32'h0040_0000, "R3 wide with bit22");
  endtask

  task automatic t_hold();
    logic [31:0] w = mk_sized(2'd3, 5'd7, 5'd8, 4'd9);
    logic [511:0] keep_lo, keep_hi;
    apply(w, rnd512(), rnd512());
    keep_lo = dl0; keep_hi = dh0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      instr = 32'hFFFF_FFFF; a = rnd512(); b = rnd512();
    end
    @(negedge clk);
    chk(dl0 == keep_lo && dh0 == keep_hi && !u0_ud && !nm0 && rl0 == 5'd18,
        "R9", "hold while idle", dl0, keep_lo);
    chk(!ov0, "R8", "out_valid drops", 512'(ov0), '0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=<100000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_sizes();
    t_patterns();
    t_wide();
    t_nomatch();
    t_hold();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule